// File: doc/BRIEF.md
# Super I/O Configuration Register Unit

This block is the configuration front end of a legacy PC peripheral controller. Software reaches it through two consecutive byte addresses on an 8-bit I/O bus. The even address holds a register pointer and the odd address carries register contents. The pair sits at one of four base addresses, chosen by a 2-bit strap. To protect against stray accesses, a data write lands in the register file only when it is the second of two data writes in a row. Any pointer write or any read in between cancels the pending sequence.

From the stored bytes the block derives registered controls for each of the following:
- the parallel port: enable, I/O base and interrupt number;
- two serial ports: enable, I/O base and interrupt number for each;
- the floppy controller: enable and primary/secondary select;
- the disk channel: enable and primary/secondary select.

A single master-off bit silences the parallel, serial and floppy enables together. A variant input picks a compact map, where only pointers 0 to 2 are writable, or an extended map, where pointers 0 to 7 are writable.

Top module: `sio_cfg_unit`

## Requirements
- R1: The unit answers only at its strap-selected base B and at B+1, with B = 0x398, 0x26E, 0x15C or 0x02E for strap value 0, 1, 2 or 3. Even offset B is the pointer and odd offset B+1 is the data byte. Writes to any other address have no effect.
- R2: A pointer write stores bits [4:0] of the written byte. A pointer read returns that 5-bit value with bits [7:5] zero.
- R3: A data write is handled as follows.
  - It commits only if the previous access to the pair was also a data write that did not itself commit.
  - A pointer write or a read of either address cancels the pending sequence.
  - Idle bus cycles in between keep the sequence pending.
- R4: A committing write is dropped when the pointer is 8, or when it exceeds the map limit: 2 with largeMap low, 8 with largeMap high.
- R5: A data read returns 0x10 for pointer 8, the stored byte for pointers 0 to 13 (zero for pointers 9 to 13), and 0xFF for pointers 14 to 31.
- R6: After reset, the registers hold the following values. All other registers read 0.
  - Register 0 is 0x4F when strapFloppy is high and 0x07 when it is low, with bit 7 also set when strapIdeSec is high.
  - Register 1 is 0x10, register 3 is 0x01, register 5 is 0x0D and register 8 is 0x70.
- R7: Register 0 drives these outputs:
  - bit 0 enables the parallel port; bits 1 and 2 enable serial ports 0 and 1; bit 3 enables the floppy controller;
  - fdcSecondary follows bit 5;
  - ideEn follows bit 6 and ideSecondary follows bit 7.
- R8: While register 2 bit 0 is set, lptEn, both serEn bits and fdcEn are low, whatever register 0 holds.
- R9: Register 1 bits [1:0] select the parallel port.
  - 0 gives 0x378 with IRQ 7 when register 2 bit 3 is set and IRQ 5 otherwise.
  - 1 gives 0x3BC with IRQ 7, and 2 gives 0x278 with IRQ 5.
  - 3 gives base 0, IRQ 0 and lptEn low.
- R10: Serial port s uses register 1 bits [3+2s:2+2s].
  - 0 gives 0x3F8 with IRQ 4, and 1 gives 0x2F8 with IRQ 3.
  - 2 gives IRQ 4 with base 0x3E8, 0x338, 0x2E8 or 0x220 for register 1 bits [7:6] = 0 to 3.
  - 3 gives IRQ 3 with base 0x2E8, 0x238, 0x2E0 or 0x228 for the same bits [7:6].
- R11: A committed byte is readable from the clock edge that samples the committing write. The decoded outputs change on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strapBase | input | 2 | Base address strap |
| strapFloppy | input | 1 | Floppy-on reset strap |
| strapIdeSec | input | 1 | Secondary disk channel reset strap |
| largeMap | input | 1 | Extended register map select |
| ioAddr | input | 16 | I/O address |
| ioWr | input | 1 | Single-cycle write strobe |
| ioRd | input | 1 | Single-cycle read strobe |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Combinational read data (0xFF when not read) |
| lptEn | output | 1 | Parallel port enable |
| lptBase | output | 16 | Parallel port base address |
| lptIrq | output | 4 | Parallel port IRQ number |
| serEn | output | 2 | Serial port enables, bit s for port s |
| serBase | output | 32 | Serial bases, port s at bits [16s+15:16s] |
| serIrq | output | 8 | Serial IRQ numbers, port s at bits [4s+3:4s] |
| fdcEn | output | 1 | Floppy controller enable |
| fdcSecondary | output | 1 | Floppy at secondary address |
| ideEn | output | 1 | Disk channel enable |
| ideSecondary | output | 1 | Disk channel at 0x170/0x376 |

## Verification
Read data is combinational, so the bench samples ioRdata one nanosecond after raising a read strobe in the same cycle. The sequence state that the read clears changes only at the next edge. A committing write is sampled at edge E and the register file changes there; the decoded outputs follow at E+1. The bench therefore compares every decoded output at the falling edge after E+1, one idle cycle after each bus operation. Checks of the reset values wait for two edges with reset high, because the outputs are a registered image of the register file.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int IDX_W      = 5;
  localparam int DATA_W     = 8;
  localparam int SMALL_MAX  = 2;
  localparam int LARGE_MAX  = 8;
  localparam int FIXED_IDX  = 8;
  localparam int READ_LIMIT = 14;
  localparam logic [DATA_W-1:0] FIXED_VAL = 8'h10;

  typedef struct packed {
    logic              commit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata;
  } cfg_strobe_t;

  typedef struct packed {
    logic [15:0] base;
    logic [3:0]  irq;
  } port_map_t;

  function automatic port_map_t lptMap(input logic [1:0] sel, input logic irqHi);
    port_map_t m;
    case (sel)
      2'd0:    m = '{base: 16'h0378, irq: irqHi ? 4'd7 : 4'd5};
      2'd1:    m = '{base: 16'h03BC, irq: 4'd7};
      2'd2:    m = '{base: 16'h0278, irq: 4'd5};
      default: m = '{base: 16'h0000, irq: 4'd0};
    endcase
    return m;
  endfunction

  function automatic port_map_t serMap(input logic [1:0] sel, input logic [1:0] alt);
    port_map_t m;
    case (sel)
      2'd0: m = '{base: 16'h03F8, irq: 4'd4};
      2'd1: m = '{base: 16'h02F8, irq: 4'd3};
      2'd2: begin
        m.irq = 4'd4;
        case (alt)
          2'd0:    m.base = 16'h03E8;
          2'd1:    m.base = 16'h0338;
          2'd2:    m.base = 16'h02E8;
          default: m.base = 16'h0220;
        endcase
      end
      default: begin
        m.irq = 4'd3;
        case (alt)
          2'd0:    m.base = 16'h02E8;
          2'd1:    m.base = 16'h0238;
          2'd2:    m.base = 16'h02E0;
          default: m.base = 16'h0228;
        endcase
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          strapBase,
  input  logic                largeMap,
  input  logic [ADDR_W-1:0]   ioAddr,
  input  logic                ioWr,
  input  logic                ioRd,
  input  logic [DATA_W-1:0]   ioWdata,
  output cfg_strobe_t         strobe,
  output logic [IDX_W-1:0]    curIdx,
  output logic                idxRd,
  output logic                datRd
);
  logic [ADDR_W-1:0] baseAddr;
  logic              hit, idxWr, datWr, anyRd, armed;
  logic [IDX_W-1:0]  maxIdx;

  always_comb begin
    case (strapBase)
      2'd0:    baseAddr = ADDR_W'(16'h0398);
      2'd1:    baseAddr = ADDR_W'(16'h026E);
      2'd2:    baseAddr = ADDR_W'(16'h015C);
      default: baseAddr = ADDR_W'(16'h002E);
    endcase
  end

  assign hit    = (ioAddr[ADDR_W-1:1] == baseAddr[ADDR_W-1:1]);
  assign idxWr  = ioWr & hit & ~ioAddr[0];
  assign datWr  = ioWr & hit & ioAddr[0];
  assign anyRd  = ioRd & hit & ~ioWr;
  assign idxRd  = anyRd & ~ioAddr[0];
  assign datRd  = anyRd & ioAddr[0];
  assign maxIdx = largeMap ? IDX_W'(LARGE_MAX) : IDX_W'(SMALL_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      curIdx <= '0;
      armed  <= 1'b0;
    end else if (idxWr) begin
      curIdx <= ioWdata[IDX_W-1:0];
      armed  <= 1'b0;
    end else if (datWr) begin
      armed  <= ~armed;
    end else if (anyRd) begin
      armed  <= 1'b0;
    end
  end

  always_comb begin
    strobe.commit = datWr & armed & (curIdx <= maxIdx) & (curIdx != IDX_W'(FIXED_IDX));
    strobe.idx    = curIdx;
    strobe.wdata  = ioWdata;
  end

  // R3
  idx_wr_disarm_chk: assert property (@(posedge clk) disable iff (rst) idxWr |=> !armed);
  // R3
  rd_disarm_chk: assert property (@(posedge clk) disable iff (rst) anyRd |=> !armed);
  // R3
  commit_disarm_chk: assert property (@(posedge clk) disable iff (rst) strobe.commit |=> !armed);
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int NREG    = 9,
  parameter int NUM_SER = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   strapFloppy,
  input  logic                   strapIdeSec,
  input  cfg_strobe_t            strobe,
  input  logic [IDX_W-1:0]       curIdx,
  input  logic                   idxRd,
  input  logic                   datRd,
  output logic [DATA_W-1:0]      rdata,
  output logic                   lptEn,
  output logic [15:0]            lptBase,
  output logic [3:0]             lptIrq,
  output logic [NUM_SER-1:0]     serEn,
  output logic [16*NUM_SER-1:0]  serBase,
  output logic [4*NUM_SER-1:0]   serIrq,
  output logic                   fdcEn,
  output logic                   fdcSecondary,
  output logic                   ideEn,
  output logic                   ideSecondary
);
  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] regVal;
  logic              gDis;
  port_map_t         lptNext;

  function automatic logic [DATA_W-1:0] resetVal(input int i, input logic fl, input logic ideS);
    case (i)
      0:       return (fl ? 8'h4F : 8'h07) | {ideS, 7'b0};
      1:       return 8'h10;
      3:       return 8'h01;
      5:       return 8'h0D;
      8:       return 8'h70;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        regs[i] <= resetVal(i, strapFloppy, strapIdeSec);
      else if (strobe.commit && strobe.idx == IDX_W'(i))
        regs[i] <= strobe.wdata;
    end
  end

  always_comb begin
    regVal = '0;
    for (int i = 0; i < NREG; i++)
      if (curIdx == IDX_W'(i)) regVal = regs[i];
    if (idxRd)
      rdata = {{(DATA_W-IDX_W){1'b0}}, curIdx};
    else if (datRd) begin
      if (curIdx == IDX_W'(FIXED_IDX))       rdata = FIXED_VAL;
      else if (curIdx < IDX_W'(READ_LIMIT))  rdata = regVal;
      else                                   rdata = 8'hFF;
    end else
      rdata = 8'hFF;
  end

  assign gDis    = regs[2][0];
  assign lptNext = lptMap(regs[1][1:0], regs[2][3]);

  always_ff @(posedge clk) begin
    lptEn        <= regs[0][0] & ~gDis & (regs[1][1:0] != 2'd3);
    lptBase      <= lptNext.base;
    lptIrq       <= lptNext.irq;
    fdcEn        <= regs[0][3] & ~gDis;
    fdcSecondary <= regs[0][5];
    ideEn        <= regs[0][6];
    ideSecondary <= regs[0][7];
  end

  for (genvar s = 0; s < NUM_SER; s++) begin : g_ser
    port_map_t serNext;
    assign serNext = serMap(regs[1][2+2*s +: 2], regs[1][7:6]);
    always_ff @(posedge clk) begin
      serEn[s]           <= regs[0][1+s] & ~gDis;
      serBase[16*s +: 16] <= serNext.base;
      serIrq[4*s +: 4]    <= serNext.irq;
    end
  end

  // R4
  fixed_reg_chk: assert property (@(posedge clk) disable iff (rst) regs[FIXED_IDX] == 8'h70);
  // R8
  gdis_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(gDis)) |-> (!lptEn && serEn == '0 && !fdcEn));
  // R7
  ide_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ideSecondary == $past(regs[0][7]) && ideEn == $past(regs[0][6])));
endmodule

// File: rtl/sio_cfg_unit.sv
module sio_cfg_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  strapBase,
  input  logic        strapFloppy,
  input  logic        strapIdeSec,
  input  logic        largeMap,
  input  logic [15:0] ioAddr,
  input  logic        ioWr,
  input  logic        ioRd,
  input  logic [7:0]  ioWdata,
  output logic [7:0]  ioRdata,
  output logic        lptEn,
  output logic [15:0] lptBase,
  output logic [3:0]  lptIrq,
  output logic [1:0]  serEn,
  output logic [31:0] serBase,
  output logic [7:0]  serIrq,
  output logic        fdcEn,
  output logic        fdcSecondary,
  output logic        ideEn,
  output logic        ideSecondary
);
  import sio_cfg_pkg::*;

  cfg_strobe_t      strobe;
  logic [IDX_W-1:0] curIdx;
  logic             idxRd, datRd;

  sio_cfg_ctrl #(.ADDR_W(16)) u_ctrl (
    .clk, .rst, .strapBase, .largeMap, .ioAddr, .ioWr, .ioRd, .ioWdata,
    .strobe, .curIdx, .idxRd, .datRd
  );

  sio_cfg_regs #(.NREG(9), .NUM_SER(2)) u_regs (
    .clk, .rst, .strapFloppy, .strapIdeSec, .strobe, .curIdx, .idxRd, .datRd,
    .rdata(ioRdata), .lptEn, .lptBase, .lptIrq, .serEn, .serBase, .serIrq,
    .fdcEn, .fdcSecondary, .ideEn, .ideSecondary
  );
endmodule

// File: tb/sim_sio_cfg_unit.sv
`timescale 1ns/1ps
module sim_sio_cfg_unit;
  logic        clk = 0, rst = 1;
  logic [1:0]  strapBase = 0;
  logic        strapFloppy = 0, strapIdeSec = 0, largeMap = 0;
  logic [15:0] ioAddr = 0;
  logic        ioWr = 0, ioRd = 0;
  logic [7:0]  ioWdata = 0;
  logic [7:0]  ioRdata;
  logic        lptEn, fdcEn, fdcSecondary, ideEn, ideSecondary;
  logic [15:0] lptBase;
  logic [3:0]  lptIrq;
  logic [1:0]  serEn;
  logic [31:0] serBase;
  logic [7:0]  serIrq;

  sio_cfg_unit u0 (.*);

  always #5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [7:0] mReg [32];
  int  mIdx;
  bit  mArm;
  logic [15:0] base;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] baseOf(logic [1:0] s);
    case (s) 0: return 16'h398; 1: return 16'h26E; 2: return 16'h15C; default: return 16'h02E; endcase
  endfunction

  task automatic doReset(logic [1:0] sb, logic fl, logic ids, logic lm);
    @(negedge clk);
    rst = 1; strapBase = sb; strapFloppy = fl; strapIdeSec = ids; largeMap = lm;
    repeat (3) @(negedge clk);
    rst = 0;
    base = baseOf(sb);
    for (int i = 0; i < 32; i++) mReg[i] = 8'h00;
    mReg[0] = (fl ? 8'h4F : 8'h07) | (ids ? 8'h80 : 8'h00);
    mReg[1] = 8'h10; mReg[3] = 8'h01; mReg[5] = 8'h0D; mReg[8] = 8'h70;
    mIdx = 0; mArm = 0;
  endtask

  task automatic busWr(logic [15:0] a, logic [7:0] d);
    ioAddr = a; ioWdata = d; ioWr = 1;
    @(negedge clk);
    ioWr = 0;
    if (a == base) begin mIdx = d[4:0]; mArm = 0; end
    else if (a == base + 16'd1) begin
      if (mArm) begin
        if (mIdx <= (largeMap ? 8 : 2) && mIdx != 8) mReg[mIdx] = d;
        mArm = 0;
      end else mArm = 1;
    end
  endtask

  function automatic int expData();
    if (mIdx == 8) return 8'h10;
    if (mIdx < 14) return mReg[mIdx];
    return 8'hFF;
  endfunction

  task automatic busRd(bit dataPort, string tag);
    ioAddr = base + (dataPort ? 16'd1 : 16'd0); ioRd = 1;
    #1;
    if (dataPort) chk({tag, " data read"}, ioRdata, expData());
    else          chk({tag, " index read"}, ioRdata, mIdx);
    @(negedge clk);
    ioRd = 0; mArm = 0;
  endtask

  task automatic chkOutputs(string tag);
    logic [1:0] ls, ss, alt;
    int lb, li, sb, si;
    bit dis;
    @(negedge clk);
    dis = mReg[2][0];
    ls = mReg[1][1:0];
    case (ls)
      0: begin lb = 'h378; li = mReg[2][3] ? 7 : 5; end
      1: begin lb = 'h3BC; li = 7; end
      2: begin lb = 'h278; li = 5; end
      default: begin lb = 0; li = 0; end
    endcase
    chk({tag, " R9 lptBase"}, lptBase, lb);
    chk({tag, " R9 lptIrq"}, lptIrq, li);
    chk({tag, " R7/R8 lptEn"}, lptEn, mReg[0][0] && !dis && ls != 3);
    alt = mReg[1][7:6];
    for (int s = 0; s < 2; s++) begin
      ss = mReg[1][2+2*s +: 2];
      case (ss)
        0: begin sb = 'h3F8; si = 4; end
        1: begin sb = 'h2F8; si = 3; end
        2: begin si = 4; case (alt) 0: sb = 'h3E8; 1: sb = 'h338; 2: sb = 'h2E8; default: sb = 'h220; endcase end
        default: begin si = 3; case (alt) 0: sb = 'h2E8; 1: sb = 'h238; 2: sb = 'h2E0; default: sb = 'h228; endcase end
      endcase
      chk({tag, " R10 serBase"}, serBase[16*s +: 16], sb);
      chk({tag, " R10 serIrq"}, serIrq[4*s +: 4], si);
      chk({tag, " R7/R8 serEn"}, serEn[s], mReg[0][1+s] && !dis);
    end
    chk({tag, " R7/R8 fdcEn"}, fdcEn, mReg[0][3] && !dis);
    chk({tag, " R7 fdcSecondary"}, fdcSecondary, mReg[0][5]);
    chk({tag, " R7 ideEn"}, ideEn, mReg[0][6]);
    chk({tag, " R7 ideSecondary"}, ideSecondary, mReg[0][7]);
  endtask

  task automatic commitW(int idx, logic [7:0] d);
    busWr(base, 8'(idx)); busWr(base + 16'd1, d); busWr(base + 16'd1, d);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int cfg = 0; cfg < 4; cfg++) begin
      doReset(2'(cfg), cfg[0], cfg[1], cfg >= 2);
      // R6 reset values, R5 readout of every pointer
      chk("R1/R6 lptEn after reset", lptEn, 1);
      chkOutputs("R6 reset");
      for (int i = 0; i < 32; i++) begin
        busWr(base, 8'(i) | 8'hE0);
        busRd(0, "R2");
        busRd(1, "R5/R6");
      end
      // R4 pointer 8 never writable
      commitW(8, 8'h55); busRd(1, "R4 ptr8");
      // R4 pointer 3 writable only in extended map
      commitW(3, 8'hA5); busRd(1, "R4 ptr3 map limit");
      // R11 readable at the commit edge, outputs one edge later
      busWr(base, 8'd2); busWr(base + 16'd1, 8'h01);
      ioAddr = base + 16'd1; ioWdata = 8'h01; ioWr = 1;
      @(negedge clk); ioWr = 0; mReg[2] = 8'h01; mArm = 0;
      chk("R11 outputs not yet updated", fdcEn, cfg[0]);
      busRd(1, "R11 readable at commit edge");
      chkOutputs("R8 master off");
      commitW(2, 8'h00); chkOutputs("R8 master on");
      // R3 idle cycles keep the sequence armed
      busWr(base, 8'd1); busWr(base + 16'd1, 8'h2A);
      repeat (3) @(negedge clk);
      busWr(base + 16'd1, 8'h2A); chkOutputs("R3 idle keeps armed");
      // R3 a read between writes cancels
      busWr(base + 16'd1, 8'hFF); busRd(0, "R3"); busWr(base + 16'd1, 8'hFF);
      busRd(1, "R3 read cancels");
      // R1 foreign addresses ignored
      busWr(base + 16'd2, 8'h03); busWr(base ^ 16'h0100, 8'h04); busRd(0, "R1 foreign");
      // random mix
      for (int n = 0; n < 400; n++) begin
        int op = $urandom % 8;
        case (op)
          0: busWr(base, 8'($urandom % 16));
          1, 2, 3: busWr(base + 16'd1, 8'($urandom));
          4: busRd(1, "R3/R5 random");
          5: busRd(0, "R2 random");
          6: busWr(base + 16'd2 + 16'($urandom % 4), 8'($urandom));
          default: @(negedge clk);
        endcase
        if (op == 1 || op == 2) chkOutputs("R7-R10 random");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule